// File: doc/BRIEF.md
# Bit-Weighted 8-Bit PWM Generator

This block produces one pulse-width-modulated output whose duty cycle is set by an 8-bit data word. It does not compare a counter against the data. Each data bit drives its own internal pulse train. Bit k is high for 2^k segments in every cycle of 256 segments. The output is the OR of the trains whose data bit is set. Because the trains are spread evenly over the cycle, the output works like a binary rate multiplier. Its high time is fragmented, which makes it easy to smooth with a simple RC filter.

A reference tick advances a prescaler. Every 16 ticks make one segment, and the segment counter wraps from 255 to 0 with no gap. A bus-side write strobe loads the data word, and the new value takes effect straight away, not at the end of the cycle. A stop control freezes the count source. An output enable and a polarity select set the level at the pin. While the block is stopped or disabled, the pin rests at the inactive level chosen by the polarity select.

Top module: `bw_pwm8`

## Requirements
- R1: With polarity 0, output enabled and the count source running, the output is high for exactly D×16 reference ticks per 4096-tick cycle, where D is the data word read as an unsigned number. This holds for D from 0 to 255.
- R2: Segment s (0..255) is active when some data bit k (7 = MSB) is 1 and counter bit (7−k) of s is 1 and all lower counter bits of s are 0. At most one bit train is active in any segment, so the number of rising edges per cycle equals the number of separate active runs of this pattern.
- R3: Segment 0 is never active, so a fully high cycle is never produced. D = 0xFF yields 255/256 high with one rising edge per cycle.
- R4: A segment lasts SEG_TICKS (16) reference ticks, not clock cycles. With wr_i and all controls steady and tick_i asserted on every second clock, each per-cycle count doubles.
- R5: A write on wr_i updates the data register on that clock edge. The output reflects the new word on the second rising edge after the write is presented, even in the middle of a cycle.
- R6: While stop_i is 1, the segment counter holds and the output rests at the inactive level, which is pol_i.
- R7: While out_en_i is 0, the output equals pol_i.
- R8: With pol_i = 1, the output is the inverse of the polarity-0 waveform, giving (256−D)×16 high ticks per cycle.
- R9: After reset the data word is 0 and pwm_o is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick, one count-source step |
| wr_i | input | 1 | Data write strobe |
| wdata_i | input | 8 | Data word to load |
| stop_i | input | 1 | 1 freezes the count source |
| out_en_i | input | 1 | 1 selects PWM output at the pin |
| pol_i | input | 1 | 0 true output, 1 inverted output |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The embedded properties assume that tick_i, stop_i, out_en_i and pol_i are synchronous to clk_i and free of unknowns after reset. They also assume a write lasts one clock, so the data register follows the previous cycle's bus word. The stimulus drives every input on the falling edge and pulses wr_i for exactly one clock. Between measurement windows it changes controls only while it is idle, so each measured period sees one steady configuration.

// File: rtl/bw_pwm8_pkg.sv
package bw_pwm8_pkg;
  localparam int unsigned DATA_W_DEF    = 8;
  localparam int unsigned SEG_TICKS_DEF = 16;

  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } pol_e;
endpackage

// File: rtl/bw_pwm8_presc.sv
module bw_pwm8_presc #(
  parameter int unsigned SEG_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stop_i,
  output logic adv_o
);
  localparam int unsigned PRE_W = (SEG_TICKS > 1) ? $clog2(SEG_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SEG_TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             step;

  assign step  = tick_i & ~stop_i;
  assign adv_o = step & (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (adv_o) pre_q <= '0;
    else if (step)  pre_q <= pre_q + 1'b1;
  end

  // R6
  presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || !tick_i) |=> $stable(pre_q));
endmodule

// File: rtl/bw_pwm8_segcnt.sv
module bw_pwm8_segcnt #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [DATA_W-1:0] seg_o
);
  logic [DATA_W-1:0] seg_q;

  // wraps naturally from all-ones to zero, no gap segment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seg_q <= '0;
    else if (adv_i) seg_q <= seg_q + 1'b1;
  end

  assign seg_o = seg_q;

  // R1
  seg_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (&seg_q)) |=> (seg_q == '0));
endmodule

// File: rtl/bw_pwm8_decode.sv
module bw_pwm8_decode #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] seg_i,
  output logic [DATA_W-1:0] pulse_o
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    localparam int unsigned J = DATA_W - 1 - k;
    localparam logic [DATA_W-1:0] LOW_MASK = {DATA_W{1'b1}} >> (DATA_W - J);
    assign pulse_o[k] = seg_i[J] & ((seg_i & LOW_MASK) == '0);
  end

  always_comb begin
    // R2
    pulse_excl_chk: assert ($onehot0(pulse_o) || $isunknown(seg_i));
    // R3
    seg0_idle_chk: assert ((seg_i != '0) || (pulse_o == '0) || $isunknown(seg_i));
  end
endmodule

// File: rtl/bw_pwm8_out.sv
module bw_pwm8_out #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pulse_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              run_i,
  input  logic              pol_i,
  output logic              pwm_o
);
  logic raw;
  logic pwm_q;

  assign raw = |(pulse_i & data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pwm_q <= 1'b0;
    else if (run_i) pwm_q <= raw ^ pol_i;
    else            pwm_q <= pol_i;
  end

  assign pwm_o = pwm_q;

  // R7
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pwm_o == $past(pol_i)));
  // R1
  zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && data_i == '0) |=> (pwm_o == $past(pol_i)));
endmodule

// File: rtl/bw_pwm8.sv
module bw_pwm8
  import bw_pwm8_pkg::*;
#(
  parameter int unsigned DATA_W    = DATA_W_DEF,
  parameter int unsigned SEG_TICKS = SEG_TICKS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stop_i,
  input  logic              out_en_i,
  input  logic              pol_i,
  output logic              pwm_o
);
  logic              adv;
  logic [DATA_W-1:0] seg;
  logic [DATA_W-1:0] pulse;
  logic [DATA_W-1:0] data_q;
  logic              run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (wr_i) data_q <= wdata_i;
  end

  assign run = out_en_i & ~stop_i;

  bw_pwm8_presc #(.SEG_TICKS(SEG_TICKS)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .stop_i(stop_i),
    .adv_o (adv)
  );

  bw_pwm8_segcnt #(.DATA_W(DATA_W)) i_segcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .seg_o (seg)
  );

  bw_pwm8_decode #(.DATA_W(DATA_W)) i_decode (
    .seg_i  (seg),
    .pulse_o(pulse)
  );

  bw_pwm8_out #(.DATA_W(DATA_W)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse),
    .data_i (data_q),
    .run_i  (run),
    .pol_i  (pol_i),
    .pwm_o  (pwm_o)
  );

  // R5
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (data_q == $past(wdata_i)));
  // R6
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(seg));
endmodule

// File: tb/test_bw_pwm8.sv
module test_bw_pwm8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tick_div = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       stop = 1'b0;
  logic       oen = 1'b1;
  logic       pol = 1'b0;
  wire        pwm;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    win;
    int    exp_high;
    int    exp_rise;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  bw_pwm8 i_bw_pwm8 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .wr_i    (wr),
    .wdata_i (wdata),
    .stop_i  (stop),
    .out_en_i(oen),
    .pol_i   (pol),
    .pwm_o   (pwm)
  );

  always @(negedge clk) tick <= tick_div ? ~tick : 1'b1;

  function automatic bit seg_act(int s, logic [7:0] d);
    for (int k = 0; k < 8; k++) begin
      int j = 7 - k;
      if (d[k] && s[j] && ((s & ((1 << j) - 1)) == 0)) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int exp_rises(logic [7:0] d, logic p, logic act);
    int r = 0;
    for (int s = 0; s < 256; s++) begin
      bit cur  = act ? (seg_act(s, d) ^ p) : p;
      bit prev = act ? (seg_act((s + 255) % 256, d) ^ p) : p;
      if (cur && !prev) r++;
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: configure, push expectation, wait for monitor
  task automatic run(string req, logic [7:0] d, logic e, logic st, logic p, bit div);
    int ticks_per_seg = div ? 32 : 16;
    int highs;
    bit act;
    oen = e; stop = st; pol = p; tick_div = div;
    write(d);
    @(negedge clk);
    act = e && !st;
    highs = act ? (p ? (256 - d) : d) * ticks_per_seg : (p ? 256 * ticks_per_seg : 0);
    sb_q.push_back('{req, 256 * ticks_per_seg, highs, exp_rises(d, p, act)});
    wait (done);
    done = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      int hi, ri;
      logic prev;
      wait (sb_q.size() > 0);
      it = sb_q[0];
      hi = 0; ri = 0;
      @(negedge clk);
      prev = pwm;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        if (pwm) hi++;
        if (pwm && !prev) ri++;
        prev = pwm;
      end
      check({it.req, " high"}, hi, it.exp_high);
      check({it.req, " rises"}, ri, it.exp_rise);
      void'(sb_q.pop_front());
      done = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pwm after reset", int'(pwm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 pwm out of reset", int'(pwm), 0);
    // R9 data defaults to zero: write nothing, expect no high time
    sb_q.push_back('{"R9", 4096, 0, 0});
    wait (done); done = 1'b0;

    run("R1", 8'h01, 1, 0, 0, 0);
    run("R1", 8'hA5, 1, 0, 0, 0);
    run("R2", 8'h80, 1, 0, 0, 0);
    run("R2", 8'h40, 1, 0, 0, 0);
    run("R2", 8'h3C, 1, 0, 0, 0);
    run("R3", 8'hFF, 1, 0, 0, 0);
    run("R4", 8'h21, 1, 0, 0, 1);
    run("R8", 8'h5A, 1, 0, 1, 0);
    run("R8", 8'h00, 1, 0, 1, 0);
    run("R7", 8'h77, 0, 0, 0, 0);
    run("R7", 8'h77, 0, 0, 1, 0);
    run("R6", 8'hFF, 1, 1, 0, 0);
    run("R6", 8'hFF, 1, 1, 1, 0);
    run("R6 resume", 8'hFF, 1, 0, 0, 0);

    // R5 mid-cycle write takes effect at once
    while (pwm !== 1'b1) @(negedge clk);
    wr = 1'b1; wdata = 8'h00;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    check("R5 write 00 mid-cycle", int'(pwm), 0);
    repeat (20) begin
      @(negedge clk);
      check("R5 stays low", int'(pwm), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule